// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic core of a small accumulator-style processor. It is purely combinational. Each evaluation takes:

- an operation code;
- a primary operand on `a_in`, which carries whichever register the instruction names;
- a secondary operand on `m_in`, normally the memory or immediate value;
- the incoming carry and overflow flags.

From these it returns a result, new negative, zero, carry and overflow flag values, a four-bit mask of the flags the operation updates, and a write-enable. The write-enable tells the surrounding datapath whether the result should go back into a register.

All arithmetic shares one adder:

- Subtraction and compare feed it the inverted secondary operand.
- Increment and decrement feed it a constant.

Compare and bit test each touch their own subset of flags and leave the register untouched. For that reason the update mask and the write-enable are part of the interface, not decoded again elsewhere. A flag that an operation does not update is driven out equal to its incoming value. Negative and zero are updated by every defined operation.

Top module: `acc_alu`

## Requirements
- R1: Add (op 0) outputs the low 8 bits of `a_in + m_in + c_in`. Carry is set when that 9-bit sum exceeds 0xFF.
- R2: For add and subtract, overflow is bit 7 of `~(a ^ b) & (a ^ r)`, where `b` is the operand actually fed to the adder and `r` is the result. It is therefore set only when both adder inputs share a sign that the result lacks.
- R3: Subtract with borrow (op 1) adds `a_in`, the bitwise inverse of `m_in`, and `c_in`, with the same carry and overflow rules as add.
- R4: For every operation except bit test, negative equals result bit 7 and zero is set exactly when the result is 0x00.
- R5: Compare (op 2) outputs the difference `a_in - m_in` modulo 256. Carry is set when `a_in >= m_in` (unsigned). Overflow passes through from `v_in` and the write-enable is 0.
- R6: AND (op 3), OR (op 4) and XOR (op 5) output the bitwise result. Carry and overflow pass through from `c_in` and `v_in`.
- R7: Bit test (op 6) sets zero when `a_in & m_in` is 0, copies `m_in[7]` into negative and `m_in[6]` into overflow, and passes carry through. The result equals `a_in` and the write-enable is 0.
- R8: Shift left (op 7) moves `a_in[7]` into carry and fills bit 0 with 0. Shift right (op 8) moves `a_in[0]` into carry and fills bit 7 with 0. Overflow passes through in both.
- R9: Rotate left (op 9) puts `c_in` into bit 0 and `a_in[7]` into carry. Rotate right (op 10) puts `c_in` into bit 7 and `a_in[0]` into carry. Overflow passes through in both.
- R10: Increment (op 11) and decrement (op 12) act on `a_in` modulo 256. Carry and overflow pass through.
- R11: `upd_mask` bit 3 is negative, bit 2 zero, bit 1 carry and bit 0 overflow. Its value and `res_we` per operation are:
  - ops 0 and 1: mask 1111, write 1;
  - op 2: mask 1110, write 0;
  - ops 3 to 5: mask 1100, write 1;
  - op 6: mask 1101, write 0;
  - ops 7 to 10: mask 1110, write 1;
  - ops 11 and 12: mask 1100, write 1.
- R12: Codes 13 to 15 are reserved. They output `a_in` as the result, mask 0000 and write-enable 0, and pass carry and overflow through. Negative and zero follow the result as in R4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (R11 lists the codes) |
| a_in | input | 8 | Primary operand (register side) |
| m_in | input | 8 | Secondary operand (memory or immediate side) |
| c_in | input | 1 | Incoming carry flag |
| v_in | input | 1 | Incoming overflow flag |
| res_out | output | 8 | Operation result |
| n_out | output | 1 | Negative flag value |
| z_out | output | 1 | Zero flag value |
| c_out | output | 1 | Carry flag value |
| v_out | output | 1 | Overflow flag value |
| upd_mask | output | 4 | Flags this operation updates, {N, Z, C, V} |
| res_we | output | 1 | Result should be written back |

## Verification
Carry-out and signed overflow come from the same adder evaluation. Add 0x80 + 0x80 and subtract cases near the sign boundary therefore raise both together, with zero also set. The bench judges each flag against a reference that derives overflow from signed integer range rather than from the bit formula. The sweep over every operand pair, both carry values and every operation code also covers the case where pass-through and computed flags meet in one result. That case is a shift or compare that updates carry but not overflow, and `v_out` is checked against the toggled `v_in`.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_SUB  = 4'd1,
        OP_CMP  = 4'd2,
        OP_AND  = 4'd3,
        OP_OR   = 4'd4,
        OP_XOR  = 4'd5,
        OP_BIT  = 4'd6,
        OP_SHL  = 4'd7,
        OP_SHR  = 4'd8,
        OP_ROL  = 4'd9,
        OP_ROR  = 4'd10,
        OP_INC  = 4'd11,
        OP_DEC  = 4'd12,
        OP_RS13 = 4'd13,
        OP_RS14 = 4'd14,
        OP_RS15 = 4'd15
    } alu_op_e;

    typedef struct packed {
        logic n;
        logic z;
        logic c;
        logic v;
    } nzcv_t;

    localparam nzcv_t UPD_ALL   = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b1};
    localparam nzcv_t UPD_NZC   = '{n: 1'b1, z: 1'b1, c: 1'b1, v: 1'b0};
    localparam nzcv_t UPD_NZ    = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b0};
    localparam nzcv_t UPD_NZV   = '{n: 1'b1, z: 1'b1, c: 1'b0, v: 1'b1};
    localparam nzcv_t UPD_NONE  = '{n: 1'b0, z: 1'b0, c: 1'b0, v: 1'b0};

endpackage

// File: rtl/acc_alu_adder.sv
module acc_alu_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    localparam int MSB = W - 1;

    logic [W:0]   wide_d;
    logic [W-1:0] sgn_d;

    always_comb begin
        wide_d = {1'b0, a_i} + {1'b0, b_i} + {{W{1'b0}}, cin_i};
        sgn_d  = ~(a_i ^ b_i) & (a_i ^ wide_d[W-1:0]);
    end

    assign sum_o  = wide_d[W-1:0];
    assign cout_o = wide_d[W];
    assign ovf_o  = sgn_d[MSB];

    always_comb begin
        if (a_i[MSB] != b_i[MSB]) begin
            // R2
            no_overflow_chk: assert (!ovf_o)
                else $error("overflow raised on mixed-sign adder inputs");
        end
    end

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] m_i,
    output logic [W-1:0] res_o,
    output logic         bitz_o
);
    logic [W-1:0] and_d;
    logic [W-1:0] or_d;
    logic [W-1:0] xor_d;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign and_d[i] = a_i[i] & m_i[i];
        assign or_d[i]  = a_i[i] | m_i[i];
        assign xor_d[i] = a_i[i] ^ m_i[i];
    end

    always_comb begin
        unique case (op_i)
            OP_OR:   res_o = or_d;
            OP_XOR:  res_o = xor_d;
            default: res_o = and_d;
        endcase
        bitz_o = ~|and_d;
    end

    always_comb begin
        if (op_i == OP_OR) begin
            // R6
            or_cover_chk: assert ((res_o & a_i) == a_i && (res_o & m_i) == m_i)
                else $error("OR result does not cover both operands");
        end
    end

endmodule

// File: rtl/acc_alu_shift.sv
module acc_alu_shift
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic         cin_i,
    output logic [W-1:0] res_o,
    output logic         cout_o
);
    localparam int MSB = W - 1;

    always_comb begin
        res_o  = a_i;
        cout_o = cin_i;
        case (op_i)
            OP_SHL: begin
                res_o  = {a_i[MSB-1:0], 1'b0};
                cout_o = a_i[MSB];
            end
            OP_SHR: begin
                res_o  = {1'b0, a_i[MSB:1]};
                cout_o = a_i[0];
            end
            OP_ROL: begin
                res_o  = {a_i[MSB-1:0], cin_i};
                cout_o = a_i[MSB];
            end
            OP_ROR: begin
                res_o  = {cin_i, a_i[MSB:1]};
                cout_o = a_i[0];
            end
            default: begin
                res_o  = a_i;
                cout_o = cin_i;
            end
        endcase
    end

    always_comb begin
        if (op_i == OP_ROL || op_i == OP_ROR) begin
            // R9
            rotate_ones_chk: assert ($countones({cout_o, res_o}) == $countones({cin_i, a_i}))
                else $error("rotate through carry lost or gained a bit");
        end
        if (op_i == OP_SHR) begin
            // R8
            shift_fill_chk: assert (res_o[MSB] == 1'b0)
                else $error("right shift did not fill the top bit with zero");
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [3:0]   op_sel,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] m_in,
    input  logic         c_in,
    input  logic         v_in,
    output logic [W-1:0] res_out,
    output logic         n_out,
    output logic         z_out,
    output logic         c_out,
    output logic         v_out,
    output logic [3:0]   upd_mask,
    output logic         res_we
);
    localparam int MSB = W - 1;

    typedef struct packed {
        logic [W-1:0] res;
        nzcv_t        flg;
        nzcv_t        upd;
        logic         we;
    } alu_out_t;

    alu_op_e      op;
    logic [W-1:0] add_b_d;
    logic         add_cin_d;
    logic [W-1:0] add_sum;
    logic         add_cout;
    logic         add_ovf;
    logic [W-1:0] lu_res;
    logic         lu_bitz;
    logic [W-1:0] sh_res;
    logic         sh_cout;
    alu_out_t     out_d;

    assign op = alu_op_e'(op_sel);

    // operand steering for the shared adder
    always_comb begin
        case (op)
            OP_SUB: begin
                add_b_d   = ~m_in;
                add_cin_d = c_in;
            end
            OP_CMP: begin
                add_b_d   = ~m_in;
                add_cin_d = 1'b1;
            end
            OP_INC: begin
                add_b_d   = '0;
                add_cin_d = 1'b1;
            end
            OP_DEC: begin
                add_b_d   = '1;
                add_cin_d = 1'b0;
            end
            default: begin
                add_b_d   = m_in;
                add_cin_d = c_in;
            end
        endcase
    end

    acc_alu_adder #(.W(W)) adder_i (
        .a_i    (a_in),
        .b_i    (add_b_d),
        .cin_i  (add_cin_d),
        .sum_o  (add_sum),
        .cout_o (add_cout),
        .ovf_o  (add_ovf)
    );

    acc_alu_logic #(.W(W)) logic_i (
        .op_i   (op),
        .a_i    (a_in),
        .m_i    (m_in),
        .res_o  (lu_res),
        .bitz_o (lu_bitz)
    );

    acc_alu_shift #(.W(W)) shift_i (
        .op_i   (op),
        .a_i    (a_in),
        .cin_i  (c_in),
        .res_o  (sh_res),
        .cout_o (sh_cout)
    );

    // result select and flag formation
    always_comb begin
        out_d       = '0;
        out_d.res   = a_in;
        out_d.flg.c = c_in;
        out_d.flg.v = v_in;
        out_d.upd   = UPD_NONE;
        out_d.we    = 1'b0;

        case (op)
            OP_ADD, OP_SUB: begin
                out_d.res   = add_sum;
                out_d.flg.c = add_cout;
                out_d.flg.v = add_ovf;
                out_d.upd   = UPD_ALL;
                out_d.we    = 1'b1;
            end
            OP_CMP: begin
                out_d.res   = add_sum;
                out_d.flg.c = add_cout;
                out_d.upd   = UPD_NZC;
            end
            OP_AND, OP_OR, OP_XOR: begin
                out_d.res = lu_res;
                out_d.upd = UPD_NZ;
                out_d.we  = 1'b1;
            end
            OP_BIT: begin
                out_d.res   = a_in;
                out_d.flg.v = m_in[MSB-1];
                out_d.upd   = UPD_NZV;
            end
            OP_SHL, OP_SHR, OP_ROL, OP_ROR: begin
                out_d.res   = sh_res;
                out_d.flg.c = sh_cout;
                out_d.upd   = UPD_NZC;
                out_d.we    = 1'b1;
            end
            OP_INC, OP_DEC: begin
                out_d.res = add_sum;
                out_d.upd = UPD_NZ;
                out_d.we  = 1'b1;
            end
            default: begin
                out_d.res = a_in;
            end
        endcase

        if (op == OP_BIT) begin
            out_d.flg.n = m_in[MSB];
            out_d.flg.z = lu_bitz;
        end else begin
            out_d.flg.n = out_d.res[MSB];
            out_d.flg.z = ~|out_d.res;
        end
    end

    assign res_out  = out_d.res;
    assign n_out    = out_d.flg.n;
    assign z_out    = out_d.flg.z;
    assign c_out    = out_d.flg.c;
    assign v_out    = out_d.flg.v;
    assign upd_mask = out_d.upd;
    assign res_we   = out_d.we;

    always_comb begin
        if (op == OP_CMP) begin
            // R5
            cmp_carry_chk: assert (c_out == (a_in >= m_in))
                else $error("compare carry disagrees with unsigned order");
        end
        if (op == OP_BIT) begin
            // R7
            bit_test_chk: assert (res_out == a_in && !res_we && z_out == ((a_in & m_in) == '0))
                else $error("bit test changed the register or misjudged zero");
        end
        if (!upd_mask[1]) begin
            // R6
            pass_carry_chk: assert (c_out == c_in)
                else $error("carry moved although not in the update mask");
        end
        if (op == OP_INC) begin
            // R10
            inc_wrap_chk: assert (res_out == W'(a_in + 1'b1))
                else $error("increment did not wrap modulo 2^W");
        end
        if (op != OP_BIT) begin
            // R4
            zero_flag_chk: assert (z_out == (res_out == '0) && n_out == res_out[MSB])
                else $error("negative/zero disagree with the result");
        end
    end

endmodule

// File: tb/acc_alu_tb_top.sv
module acc_alu_tb_top;

    localparam int NVEC     = 20;
    localparam int WD_LIMIT = 190000;

    logic       clk = 1'b0;
    logic [3:0] op_sel;
    logic [7:0] a_in, m_in;
    logic       c_in, v_in;
    logic [7:0] res_out;
    logic       n_out, z_out, c_out, v_out;
    logic [3:0] upd_mask;
    logic       res_we;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    acc_alu #(.W(8)) dut_i (
        .op_sel   (op_sel),
        .a_in     (a_in),
        .m_in     (m_in),
        .c_in     (c_in),
        .v_in     (v_in),
        .res_out  (res_out),
        .n_out    (n_out),
        .z_out    (z_out),
        .c_out    (c_out),
        .v_out    (v_out),
        .upd_mask (upd_mask),
        .res_we   (res_we)
    );

    // {op, a, m, c, v, res, nzcv, mask, we}
    localparam logic [38:0] VEC [NVEC] = '{
        {4'd0,  8'h50, 8'h50, 1'b0, 1'b0, 8'hA0, 4'b1001, 4'b1111, 1'b1},
        {4'd0,  8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 4'b0110, 4'b1111, 1'b1},
        {4'd0,  8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 4'b1001, 4'b1111, 1'b1},
        {4'd1,  8'h50, 8'hF0, 1'b1, 1'b0, 8'h60, 4'b0000, 4'b1111, 1'b1},
        {4'd1,  8'h50, 8'hB0, 1'b1, 1'b0, 8'hA0, 4'b1001, 4'b1111, 1'b1},
        {4'd1,  8'h05, 8'h05, 1'b0, 1'b0, 8'hFF, 4'b1000, 4'b1111, 1'b1},
        {4'd2,  8'h40, 8'h40, 1'b0, 1'b1, 8'h00, 4'b0111, 4'b1110, 1'b0},
        {4'd2,  8'h10, 8'h20, 1'b1, 1'b0, 8'hF0, 4'b1000, 4'b1110, 1'b0},
        {4'd3,  8'hF0, 8'h3C, 1'b1, 1'b1, 8'h30, 4'b0011, 4'b1100, 1'b1},
        {4'd4,  8'h00, 8'h00, 1'b0, 1'b0, 8'h00, 4'b0100, 4'b1100, 1'b1},
        {4'd5,  8'hFF, 8'h7F, 1'b0, 1'b1, 8'h80, 4'b1001, 4'b1100, 1'b1},
        {4'd6,  8'h0F, 8'hC0, 1'b1, 1'b0, 8'h0F, 4'b1111, 4'b1101, 1'b0},
        {4'd7,  8'h81, 8'h00, 1'b0, 1'b0, 8'h02, 4'b0010, 4'b1110, 1'b1},
        {4'd8,  8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 4'b0110, 4'b1110, 1'b1},
        {4'd9,  8'h80, 8'h00, 1'b1, 1'b0, 8'h01, 4'b0010, 4'b1110, 1'b1},
        {4'd10, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 4'b1000, 4'b1110, 1'b1},
        {4'd11, 8'hFF, 8'h00, 1'b0, 1'b1, 8'h00, 4'b0101, 4'b1100, 1'b1},
        {4'd12, 8'h00, 8'h00, 1'b1, 1'b0, 8'hFF, 4'b1010, 4'b1100, 1'b1},
        {4'd13, 8'h00, 8'h55, 1'b1, 1'b1, 8'h00, 4'b0111, 4'b0000, 1'b0},
        {4'd0,  8'h80, 8'h80, 1'b0, 1'b0, 8'h00, 4'b0111, 4'b1111, 1'b1}
    };

    function automatic string req_of(int op);
        case (op)
            0:        return "R1";
            1:        return "R3";
            2:        return "R5";
            3, 4, 5:  return "R6";
            6:        return "R7";
            7, 8:     return "R8";
            9, 10:    return "R9";
            11, 12:   return "R10";
            default:  return "R12";
        endcase
    endfunction

    function automatic int sx(int x);
        return (x >= 128) ? x - 256 : x;
    endfunction

    // returns {res[7:0], n, z, c, v, mask[3:0], we}
    function automatic logic [16:0] ref_model(int op, int a, int m, int c, int v);
        int r, s, ss;
        logic n, z, cc, vv, we;
        logic [3:0] mk;
        cc = c[0]; vv = v[0]; r = a; we = 1'b0; mk = 4'b0000;
        case (op)
            0: begin
                s = a + m + c; r = s % 256; cc = (s > 255);
                ss = sx(a) + sx(m) + c; vv = (ss > 127 || ss < -128);
                mk = 4'b1111; we = 1'b1;
            end
            1: begin
                s = a + (255 - m) + c; r = s % 256; cc = (s > 255);
                ss = sx(a) - sx(m) - (1 - c); vv = (ss > 127 || ss < -128);
                mk = 4'b1111; we = 1'b1;
            end
            2: begin r = (a - m + 256) % 256; cc = (a >= m); mk = 4'b1110; end
            3: begin r = a & m; mk = 4'b1100; we = 1'b1; end
            4: begin r = a | m; mk = 4'b1100; we = 1'b1; end
            5: begin r = a ^ m; mk = 4'b1100; we = 1'b1; end
            6: begin r = a; vv = ((m / 64) % 2) == 1; mk = 4'b1101; end
            7: begin r = (a * 2) % 256; cc = (a >= 128); mk = 4'b1110; we = 1'b1; end
            8: begin r = a / 2; cc = (a % 2) == 1; mk = 4'b1110; we = 1'b1; end
            9: begin r = (a * 2 + c) % 256; cc = (a >= 128); mk = 4'b1110; we = 1'b1; end
            10: begin r = a / 2 + c * 128; cc = (a % 2) == 1; mk = 4'b1110; we = 1'b1; end
            11: begin r = (a + 1) % 256; mk = 4'b1100; we = 1'b1; end
            12: begin r = (a + 255) % 256; mk = 4'b1100; we = 1'b1; end
            default: begin r = a; end
        endcase
        if (op == 6) begin
            n = (m >= 128);
            z = ((a & m) == 0);
        end else begin
            n = (r >= 128);
            z = (r == 0);
        end
        return {r[7:0], n, z, cc, vv, mk, we};
    endfunction

    task automatic apply_and_check(int op, int a, int m, int c, int v,
                                   logic [16:0] exp, string tag);
        logic [16:0] got;
        op_sel = op[3:0]; a_in = a[7:0]; m_in = m[7:0]; c_in = c[0]; v_in = v[0];
        #1;
        got = {res_out, n_out, z_out, c_out, v_out, upd_mask, res_we};
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%02h m=%02h c=%0d v=%0d actual=%05h expected=%05h",
                     tag, op, a, m, c, v, got, exp);
        end
    endtask

    task automatic run_all();
        // table of hand-computed vectors, incl. carry+overflow together (R2)
        for (int i = 0; i < NVEC; i++) begin
            int op;
            op = int'(VEC[i][38:35]);
            apply_and_check(op, int'(VEC[i][34:27]), int'(VEC[i][26:19]),
                            int'(VEC[i][18]), int'(VEC[i][17]), VEC[i][16:0],
                            (op == 0 && i == NVEC - 1) ? "R2" : req_of(op));
        end

        // mask and write-enable per code, R11
        for (int op = 0; op < 16; op++) begin
            apply_and_check(op, 8'h3C, 8'hA5, 1, 0, ref_model(op, 8'h3C, 8'hA5, 1, 0), "R11");
        end

        // directed corners
        apply_and_check(0, 0, 0, 0, 0, {8'h00, 4'b0100, 4'b1111, 1'b1}, "R4 idle");
        apply_and_check(1, 8'h00, 8'hFF, 0, 1, {8'h00, 4'b0100, 4'b1111, 1'b1}, "R3 borrow");
        apply_and_check(2, 8'hFF, 8'h00, 0, 0, {8'hFF, 4'b1010, 4'b1110, 1'b0}, "R5 max");
        apply_and_check(6, 8'h40, 8'h40, 0, 0, {8'h40, 4'b0001, 4'b1101, 1'b0}, "R7 bit6");
        apply_and_check(15, 8'h80, 8'h00, 0, 1, {8'h80, 4'b1001, 4'b0000, 1'b0}, "R12 rsv");

        // exhaustive sweep against the reference model
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int m = 0; m < 256; m++) begin
                    for (int c = 0; c < 2; c++) begin
                        int v;
                        v = ((a ^ m) & 1) ^ c;
                        apply_and_check(op, a, m, c, v, ref_model(op, a, m, c, v), req_of(op));
                    end
                end
            end
        end
    endtask

    initial begin
        op_sel = '0; a_in = '0; m_in = '0; c_in = 1'b0; v_in = 1'b0;
        repeat (2) @(posedge clk);
        #5;
        fork
            run_all();
            begin
                repeat (WD_LIMIT) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog: actual=timeout expected=finish within %0d cycles", WD_LIMIT);
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule